// File: doc/BRIEF.md
# Push-Button Reset and Power-Cycle Controller

This block watches an active-low push-button and acts on how long the button is held. A short press resets the host processor. The active-low reset output falls as soon as the press is seen, not when the button is let go. It stays low until the button is released, and then for a further reset timeout. A long press runs a power cycle: the regulator-enable output drops for an off-time and then returns. The processor reset stays low through the whole power cycle and for one reset timeout after the regulators come back.

An active-low button-status output follows the synchronized button, so the processor can use it as an interrupt. Each action leaves a sticky status bit. A one-bit select chooses which bit a read strobe returns, and that read clears the bit. All durations are counted in ticks of a prescaler, and every duration is a parameter. A press is accepted only on a fresh button edge while the block is idle.

Top module: `pbr_top`

## Requirements
- R1: During reset and after it, `rstOutN`=1, `regEn`=1 and `btnStatN`=1, and both status bits read 0.
- R2: `btnN` passes through a two-flop synchronizer. `btnStatN` is 0 exactly while the synchronized button is asserted, which lags `btnN` by two clock edges.
- R3: A press starts an action on the third clock edge after `btnN` falls, one edge after synchronization, used for edge detection. `rstOutN` goes to 0 on that edge.
- R4: A short press ends when the synchronized button is released while the hold count is still below the threshold. `rstOutN` returns to 1 exactly RESET_MS of ticks after the release is seen. `regEn` stays 1 throughout.
- R5: A long press is one where the button is still held when the hold count reaches HOLD_MS of ticks. At that point `regEn` goes to 0 for OFF_MS of ticks and then back to 1. `rstOutN` stays 0 the whole time and returns to 1 RESET_MS of ticks after `regEn` returns.
- R6: The soft-reset status bit is set on the edge where the release of a short press is seen.
- R7: The power-cycle status bit is set on the edge where `regEn` returns to 1.
- R8: With `rdEn`=1, `rdData` shows the soft-reset bit when `rdSel`=0 and the power-cycle bit when `rdSel`=1, in the same cycle. The selected bit is cleared at the clock edge. If an event sets that bit on the same edge, the bit ends at 1.
- R9: Button activity is ignored until the block is idle again. A button that is still held when the block becomes idle does not start a new action.
- R10: One tick lasts CLK_HZ/TICK_HZ clock cycles. The tick phase restarts at every state change, so each timed stage lasts exactly its tick count times that many cycles.
- R11: If `btnN` is held low for exactly HOLD_MS ticks' worth of cycles, the press is short. One cycle longer makes it long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| btnN | input | 1 | Debounced button, 0 = pressed |
| rdEn | input | 1 | Status read strobe, clears the selected bit |
| rdSel | input | 1 | 0 = soft-reset bit, 1 = power-cycle bit |
| rdData | output | 1 | Selected status bit |
| rstOutN | output | 1 | Processor reset, 0 = held in reset |
| btnStatN | output | 1 | Button status, 0 = button asserted |
| regEn | output | 1 | Regulator enable, 0 = regulators off |

## Verification
The assertions assume that `btnN` is driven steadily and settles between clock edges. They also assume `btnN` is high while `rstN` is low, so the synchronizer history after reset describes real presses. The stimulus changes `btnN` and the read controls only on falling clock edges and keeps the button released during reset. Random hold lengths are spread on both sides of the long-press threshold, and directed runs add a second press during the timeout, a button held past the return to idle, and reads that coincide with the setting edge.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

  typedef enum logic [2:0] {
    stIdle,
    stHeld,
    stRelWait,
    stPwrOff,
    stPwrOnWait
  } pbrState_t;

  typedef enum logic [1:0] {
    limHold,
    limReset,
    limOff
  } pbrLim_t;

  typedef struct packed {
    logic    clrTimer;
    logic    setSoft;
    logic    setCycle;
    pbrLim_t limSel;
  } pbrStrobe_t;

endpackage

// File: rtl/pbr_datapath.sv
module pbr_datapath
  import pbr_pkg::*;
#(
  parameter int DIV    = 1000,
  parameter int HOLD_T = 4000,
  parameter int RST_T  = 200,
  parameter int OFF_T  = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       btnN,
  input  logic       rdEn,
  input  logic       rdSel,
  input  pbrStrobe_t strobe,
  output logic       pressed,
  output logic       pressRise,
  output logic       timeUp,
  output logic       rdData,
  output logic       softStat,
  output logic       cycleStat
);

  localparam int MAXA = (HOLD_T > RST_T) ? HOLD_T : RST_T;
  localparam int MAXT = (MAXA > OFF_T) ? MAXA : OFF_T;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] holdLast  = CW'(HOLD_T - 1);
  localparam logic [CW-1:0] resetLast = CW'(RST_T - 1);
  localparam logic [CW-1:0] offLast   = CW'(OFF_T - 1);

  logic syncA, pressedD, tick;
  logic [CW-1:0] cnt, limLast;

  // two-flop synchronizer plus one stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      pressed  <= 1'b0;
      pressedD <= 1'b0;
    end else begin
      syncA    <= ~btnN;
      pressed  <= syncA;
      pressedD <= pressed;
    end
  end

  assign pressRise = pressed & ~pressedD;

  generate
    if (DIV > 1) begin : g_pre
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] pre;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pre <= '0;
        else if (strobe.clrTimer || pre == PW'(DIV - 1)) pre <= '0;
        else pre <= pre + 1'b1;
      end
      assign tick = (pre == PW'(DIV - 1));
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (strobe.clrTimer) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  always_comb begin
    case (strobe.limSel)
      limReset: limLast = resetLast;
      limOff:   limLast = offLast;
      default:  limLast = holdLast;
    endcase
  end

  assign timeUp = tick && (cnt == limLast);

  // read clears; a set on the same edge wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softStat  <= 1'b0;
      cycleStat <= 1'b0;
    end else begin
      softStat  <= (softStat & ~(rdEn & ~rdSel)) | strobe.setSoft;
      cycleStat <= (cycleStat & ~(rdEn & rdSel)) | strobe.setCycle;
    end
  end

  assign rdData = rdSel ? cycleStat : softStat;

endmodule

// File: rtl/pbr_ctrl.sv
module pbr_ctrl
  import pbr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pressed,
  input  logic       pressRise,
  input  logic       timeUp,
  output pbrStrobe_t strobe,
  output logic       rstOutN,
  output logic       regEn
);

  pbrState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= stIdle;
    else state <= nxt;
  end

  always_comb begin
    nxt    = state;
    strobe = '{clrTimer: 1'b0, setSoft: 1'b0, setCycle: 1'b0, limSel: limHold};
    case (state)
      stIdle: begin
        strobe.clrTimer = 1'b1;
        if (pressRise) nxt = stHeld;
      end
      stHeld: begin
        strobe.limSel = limHold;
        if (!pressed) begin
          nxt = stRelWait;
          strobe.setSoft = 1'b1;
        end else if (timeUp) begin
          nxt = stPwrOff;
        end
      end
      stRelWait: begin
        strobe.limSel = limReset;
        if (timeUp) nxt = stIdle;
      end
      stPwrOff: begin
        strobe.limSel = limOff;
        if (timeUp) begin
          nxt = stPwrOnWait;
          strobe.setCycle = 1'b1;
        end
      end
      stPwrOnWait: begin
        strobe.limSel = limReset;
        if (timeUp) nxt = stIdle;
      end
      default: nxt = stIdle;
    endcase
    if (nxt != state) strobe.clrTimer = 1'b1;
  end

  assign rstOutN = (state == stIdle);
  assign regEn   = (state != stPwrOff);

endmodule

// File: rtl/pbr_top.sv
module pbr_top
  import pbr_pkg::*;
#(
  parameter int CLK_HZ   = 1_000_000,
  parameter int TICK_HZ  = 1000,
  parameter int HOLD_MS  = 4000,
  parameter int RESET_MS = 200,
  parameter int OFF_MS   = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic btnN,
  input  logic rdEn,
  input  logic rdSel,
  output logic rdData,
  output logic rstOutN,
  output logic btnStatN,
  output logic regEn
);

  localparam int DIV    = CLK_HZ / TICK_HZ;
  localparam int HOLD_T = HOLD_MS * TICK_HZ / 1000;
  localparam int RST_T  = RESET_MS * TICK_HZ / 1000;
  localparam int OFF_T  = OFF_MS * TICK_HZ / 1000;

  pbrStrobe_t strobe;
  logic pressed, pressRise, timeUp, softStat, cycleStat;

  pbr_datapath #(
    .DIV(DIV), .HOLD_T(HOLD_T), .RST_T(RST_T), .OFF_T(OFF_T)
  ) u_dp (
    .clk(clk), .rstN(rstN), .btnN(btnN), .rdEn(rdEn), .rdSel(rdSel),
    .strobe(strobe), .pressed(pressed), .pressRise(pressRise),
    .timeUp(timeUp), .rdData(rdData), .softStat(softStat),
    .cycleStat(cycleStat)
  );

  pbr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pressed(pressed), .pressRise(pressRise),
    .timeUp(timeUp), .strobe(strobe), .rstOutN(rstOutN), .regEn(regEn)
  );

  assign btnStatN = ~pressed;

endmodule

// File: rtl/pbr_checker.sv
module pbr_checker (
  input logic clk,
  input logic rstN,
  input logic btnN,
  input logic rstOutN,
  input logic btnStatN,
  input logic regEn,
  input logic softStat,
  input logic cycleStat
);

  AST_STAT_FOLLOWS_BTN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(btnStatN) |-> !$past(btnN, 2)); // R2

  AST_RST_AFTER_PRESS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstOutN) |-> !$past(btnStatN)); // R3

  AST_OFF_HOLDS_RST: assert property (@(posedge clk) disable iff (!rstN)
    !regEn |-> !rstOutN); // R5

  AST_RST_RELEASE_POWERED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstOutN) |-> (regEn && $past(regEn))); // R5

  AST_SOFT_SET_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(softStat) |-> !rstOutN); // R6

  AST_CYCLE_SET_ON_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regEn) |-> cycleStat); // R7

endmodule

bind pbr_top pbr_checker u_chk (
  .clk(clk), .rstN(rstN), .btnN(btnN), .rstOutN(rstOutN),
  .btnStatN(btnStatN), .regEn(regEn), .softStat(softStat),
  .cycleStat(cycleStat)
);

// File: tb/pbr_top_test.sv
module pbr_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;
  localparam int HT  = 20;
  localparam int RT  = 6;
  localparam int OT  = 4;
  localparam int HD  = HT * DIV;
  localparam int RD  = RT * DIV;
  localparam int OD  = OT * DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic btnN = 1'b1;
  logic rdEn = 1'b0;
  logic rdSel = 1'b0;
  logic rdData, rstOutN, btnStatN, regEn;
  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  pbr_top #(
    .CLK_HZ(2000), .TICK_HZ(1000), .HOLD_MS(20), .RESET_MS(6), .OFF_MS(4)
  ) uut (
    .clk(clk), .rstN(rstN), .btnN(btnN), .rdEn(rdEn), .rdSel(rdSel),
    .rdData(rdData), .rstOutN(rstOutN), .btnStatN(btnStatN), .regEn(regEn)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expRise(int h);
    return (h > HD) ? (3 + HD + OD + RD) : (h + 3 + RD);
  endfunction

  task automatic readStat(bit sel, int exp, string req);
    @(negedge clk);
    rdEn = 1'b1;
    rdSel = sel;
    #1;
    check(req, int'(rdData), exp);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // Drives a press of h cycles from a falling edge; k counts edges since.
  task automatic runPress(int h, int rdAt, int pokeAt, string tag);
    bit isLong = (h > HD);
    int fallK = 0, riseK = 0, offCnt = 0, offStart = 0, statLow = 0;
    int reFall = 0;
    int last = expRise(h) > h ? expRise(h) : h;
    @(negedge clk);
    btnN = 1'b0;
    for (int k = 1; k <= last + 12; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (!rstOutN && fallK == 0) fallK = k;
      if (rstOutN && fallK != 0 && riseK == 0) riseK = k;
      if (!rstOutN && riseK != 0) reFall = 1;
      if (!regEn) begin
        offCnt++;
        if (offStart == 0) offStart = k;
      end
      if (!btnStatN) statLow++;
      if (k == h) btnN = 1'b1;
      if (pokeAt != 0 && k == pokeAt) btnN = 1'b0;
      if (pokeAt != 0 && k == pokeAt + 3) btnN = 1'b1;
      if (rdAt != 0 && k == rdAt - 1) begin
        rdEn = 1'b1;
        rdSel = isLong;
        #1;
        check({"R8 read on set edge ", tag}, int'(rdData), 0);
      end
      if (rdAt != 0 && k == rdAt) rdEn = 1'b0;
    end
    btnN = 1'b1;
    check({"R3 reset fall ", tag}, fallK, 3);
    check({isLong ? "R5" : "R4", " reset rise ", tag}, riseK, expRise(h));
    check({"R2 status low cycles ", tag}, statLow, h + (pokeAt != 0 ? 3 : 0));
    check({isLong ? "R5" : "R4", " off cycles ", tag}, offCnt, isLong ? OD : 0);
    if (isLong) check({"R10 off start ", tag}, offStart, 3 + HD);
    check({"R9 no new action ", tag}, reFall, 0);
    readStat(isLong, 1, {isLong ? "R7" : "R6", " status set ", tag});
    readStat(isLong, 0, {"R8 cleared by read ", tag});
    readStat(!isLong, 0, {"R8 other bit ", tag});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check("R1 rstOutN in reset", int'(rstOutN), 1);
    check("R1 regEn in reset", int'(regEn), 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rstOutN", int'(rstOutN), 1);
    check("R1 regEn", int'(regEn), 1);
    check("R1 btnStatN", int'(btnStatN), 1);
    readStat(1'b0, 0, "R1 soft bit");
    readStat(1'b1, 0, "R1 cycle bit");

    runPress(5, 0, 0, "short");
    runPress(1, 0, 0, "one-cycle");
    runPress(HD, 0, 0, "R11 at threshold");
    runPress(HD + 1, 0, 0, "R11 past threshold");
    runPress(8, 8 + 3, 0, "short set-wins");
    runPress(HD + 10, 3 + HD + OD, 0, "long set-wins");
    runPress(4, 0, 10, "poke during timeout");
    runPress(HD + OD + RD + 25, 0, 0, "held past idle");
    for (int i = 0; i < 12; i++) begin
      int h = 1 + int'($urandom % (2 * HD + 10));
      repeat (1 + ($urandom % 5)) @(negedge clk);
      runPress(h, 0, 0, "random R10");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule